// File: doc/BRIEF.md
# Compare-triggered sync pulse generator

This block turns a single-cycle match event from a time-counter comparator into a timed pulse on the sync0 output line. A pulse can follow the event at once or after a programmed start delay. It stays high for a programmed number of reference clock cycles. With a period of zero it fires once per event. With a nonzero period it keeps repeating for as long as it stays enabled. This makes it suitable for pulse-per-second and other periodic outputs aligned to the time base.

Software programs the block through a simple word-wide register bus. Writes are synchronous. Reads are combinational on a separate read address. A sticky status bit records that a pulse has started. Writing zero to the control register halts generation on the spot.

Top module: `cmp_sync_pulse_gen`

## Requirements
- R1: After reset, sync_out and pulse_flag are 0 and every register reads 0.
- R2: Control bit 0 is the global enable and control bit 1 enables the sync0 output. A compare event is accepted only when both bits are 1. Otherwise it produces no pulse and does not set the status bit.
- R3: Let k be the clock edge that samples cmp_hit high. With a start delay D of 0, sync_out is high in the cycle after edge k. With D > 0, sync_out rises in the cycle after edge k+D.
- R4: Each pulse holds sync_out high for exactly width cycles. A width of 0 behaves as 1.
- R5: With a period of 0, exactly one pulse is produced per accepted event. The block then waits for a new event.
- R6: With a nonzero period P greater than the width, a new pulse starts every P cycles after the first one, for as long as the block stays enabled.
- R7: Writing 0 to the control register forces sync_out low from the cycle after the write edge and returns the block to idle.
- R8: Status bit 0 (pulse_flag) is set in the same cycle that any pulse rises and stays set. Writing 1 to status bit 0 clears it. A rise in the same cycle as the clear wins.
- R9: A compare event that arrives during the start delay, during a pulse, or during the periodic phase is ignored.
- R10: The register map uses word addresses: 0 control (2 bits), 1 status (bit 0), 2 width, 3 period, 4 start delay. Reads are combinational. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_hit | input | 1 | Compare-1 match event, one cycle per match |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| sync_out | output | 1 | Sync0 pulse output |
| pulse_flag | output | 1 | Sticky pulse-occurred status bit |

## Verification
The assertions assume that a control write with both bits cleared can land at any time. They allow for this by accepting a low output right after a launch whenever the enable has gone away. Beyond that, they make no assumption about the spacing of compare events.

The periodic checks rely on a period larger than the width. The stimulus only programs such pairs. It changes width, period and delay only while the block is idle, so that each expected trace follows from the programmed values alone.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;

  // word addresses of the register bank
  localparam int ADR_CTL    = 0;
  localparam int ADR_STAT   = 1;
  localparam int ADR_WIDTH  = 2;
  localparam int ADR_PERIOD = 3;
  localparam int ADR_DELAY  = 4;

  // control field layout
  localparam int CTL_W          = 2;
  localparam int CTL_GLOBAL_BIT = 0;
  localparam int CTL_OUT0_BIT   = 1;

  // sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_ACTIVE = 2'd2
  } phase_t;

endpackage

// File: rtl/sync_pulse_regs.sv
module sync_pulse_regs
  import sync_pulse_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rise_evt,
  output logic [CTL_W-1:0] ctl_q,
  output logic [DW-1:0]    width_q,
  output logic [DW-1:0]    period_q,
  output logic [DW-1:0]    delay_q,
  output logic             flag_q,
  output logic             clr_req,
  output logic [DW-1:0]    rd_data
);

  logic hit_ctl, hit_stat, hit_width, hit_period, hit_delay;

  assign hit_ctl    = wr_en && (wr_addr == AW'(ADR_CTL));
  assign hit_stat   = wr_en && (wr_addr == AW'(ADR_STAT));
  assign hit_width  = wr_en && (wr_addr == AW'(ADR_WIDTH));
  assign hit_period = wr_en && (wr_addr == AW'(ADR_PERIOD));
  assign hit_delay  = wr_en && (wr_addr == AW'(ADR_DELAY));

  // write-one-to-clear request on status bit 0
  assign clr_req = hit_stat && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      width_q  <= '0;
      period_q <= '0;
      delay_q  <= '0;
    end else begin
      if (hit_ctl)    ctl_q    <= wr_data[CTL_W-1:0];
      if (hit_width)  width_q  <= wr_data;
      if (hit_period) period_q <= wr_data;
      if (hit_delay)  delay_q  <= wr_data;
    end
  end

  // sticky flag: a launch takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (rise_evt) flag_q <= 1'b1;
    else if (clr_req)  flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(ADR_CTL):    rd_data = DW'(ctl_q);
      AW'(ADR_STAT):   rd_data = DW'(flag_q);
      AW'(ADR_WIDTH):  rd_data = width_q;
      AW'(ADR_PERIOD): rd_data = period_q;
      AW'(ADR_DELAY):  rd_data = delay_q;
      default:         rd_data = '0;
    endcase
  end

endmodule

// File: rtl/sync_pulse_seq.sv
module sync_pulse_seq
  import sync_pulse_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_en,
  input  logic          cmp_hit,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] delay,
  output logic          rise_evt,
  output logic          sync_out
);

  localparam logic [DW-1:0] ONE = DW'(1);

  // width of 0 is treated as a single cycle
  function automatic logic [DW-1:0] eff_width(input logic [DW-1:0] w);
    return (w == '0) ? ONE : w;
  endfunction

  // delay phase is over once the counter has reached the programmed delay
  function automatic logic delay_done(input logic [DW-1:0] r, input logic [DW-1:0] d);
    return r >= d;
  endfunction

  // periodic mode: the cycle that restarts the pulse
  function automatic logic period_wrap(input logic [DW-1:0] r, input logic [DW-1:0] p);
    return (p != '0) && (r >= p - ONE);
  endfunction

  // one-shot mode: last high cycle of the pulse
  function automatic logic width_done(input logic [DW-1:0] r, input logic [DW-1:0] w);
    return r >= eff_width(w) - ONE;
  endfunction

  phase_t        phase_q;
  logic [DW-1:0] run_q;

  logic launch_now, launch_late, launch_again;

  assign launch_now   = sync_en && (phase_q == PH_IDLE) && cmp_hit && (delay == '0);
  assign launch_late  = sync_en && (phase_q == PH_DELAY) && delay_done(run_q, delay);
  assign launch_again = sync_en && (phase_q == PH_ACTIVE) && period_wrap(run_q, period);
  assign rise_evt     = launch_now || launch_late || launch_again;

  always_ff @(posedge clk) begin
    if (!rst_n || !sync_en) begin
      phase_q <= PH_IDLE;
      run_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (cmp_hit) begin
            if (delay == '0) begin
              phase_q <= PH_ACTIVE;
              run_q   <= '0;
            end else begin
              phase_q <= PH_DELAY;
              run_q   <= ONE;
            end
          end
        end
        PH_DELAY: begin
          if (delay_done(run_q, delay)) begin
            phase_q <= PH_ACTIVE;
            run_q   <= '0;
          end else begin
            run_q <= run_q + ONE;
          end
        end
        PH_ACTIVE: begin
          if (period != '0) begin
            run_q <= period_wrap(run_q, period) ? '0 : run_q + ONE;
          end else if (width_done(run_q, width)) begin
            phase_q <= PH_IDLE;
            run_q   <= '0;
          end else begin
            run_q <= run_q + ONE;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          run_q   <= '0;
        end
      endcase
    end
  end

  // enable gating makes a disable write take effect in the very next cycle
  assign sync_out = sync_en && (phase_q == PH_ACTIVE) && (run_q < eff_width(width));

endmodule

// File: rtl/cmp_sync_pulse_gen.sv
module cmp_sync_pulse_gen
  import sync_pulse_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_hit,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sync_out,
  output logic          pulse_flag
);

  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    width_q, period_q, delay_q;
  logic             sync_en;
  logic             rise_evt;
  logic             clr_req;

  assign sync_en = ctl_q[CTL_GLOBAL_BIT] && ctl_q[CTL_OUT0_BIT];

  sync_pulse_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rise_evt (rise_evt),
    .ctl_q    (ctl_q),
    .width_q  (width_q),
    .period_q (period_q),
    .delay_q  (delay_q),
    .flag_q   (pulse_flag),
    .clr_req  (clr_req),
    .rd_data  (rd_data)
  );

  sync_pulse_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_en  (sync_en),
    .cmp_hit  (cmp_hit),
    .width    (width_q),
    .period   (period_q),
    .delay    (delay_q),
    .rise_evt (rise_evt),
    .sync_out (sync_out)
  );

endmodule

// File: rtl/sync_pulse_chk.sv
module sync_pulse_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_en,
  input logic sync_out,
  input logic pulse_flag,
  input logic rise_evt,
  input logic clr_req
);

  // R7
  off_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !sync_out);

  // R3
  launch_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (sync_out || !sync_en));

  // R8
  launch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> pulse_flag);

  // R8
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !rise_evt) |=> !pulse_flag);

  // R2
  no_launch_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |-> !rise_evt);

endmodule

bind cmp_sync_pulse_gen sync_pulse_chk u_sync_pulse_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_en    (sync_en),
  .sync_out   (sync_out),
  .pulse_flag (pulse_flag),
  .rise_evt   (rise_evt),
  .clr_req    (clr_req)
);

// File: tb/cmp_sync_pulse_gen_bench.sv
module cmp_sync_pulse_gen_bench;

  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_hit = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          sync_out;
  logic          pulse_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  s;
    logic  f;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  cmp_sync_pulse_gen #(.DW(DW), .AW(AW)) u_cmp_sync_pulse_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_hit    (cmp_hit),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .sync_out   (sync_out),
    .pulse_flag (pulse_flag)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares the scoreboard against the outputs mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " sync_out"}, DW'(sync_out), DW'(e.s));
      check({e.tag, " pulse_flag"}, DW'(pulse_flag), DW'(e.f));
    end
  end

  // caller sits just after a rising edge
  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string tag, int a, int exp);
    rd_addr = AW'(a);
    @(negedge clk);
    check(tag, rd_data, DW'(exp));
    @(posedge clk); #2;
  endtask

  // driver: programs a trial, fires one event and pushes the expected trace
  task automatic trial(int d, int w, int p, int n, int retrig, string tag);
    int weff;
    weff = (w == 0) ? 1 : w;
    wr(2, w); wr(3, p); wr(4, d); wr(0, 3); wr(1, 1);
    cmp_hit = 1'b1;
    @(posedge clk); #2;
    cmp_hit = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int r;
      r = i - d;
      if (i < d) e.s = 1'b0;
      else if (p == 0) e.s = (r < weff);
      else e.s = ((r % p) < weff);
      e.f = (i >= d);
      e.tag = tag;
      sb.push_back(e);
    end
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #2;
      cmp_hit = (j == retrig);
    end
    cmp_hit = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state, R10 reset read-back
    @(negedge clk);
    check("R1 sync_out", DW'(sync_out), '0);
    check("R1 pulse_flag", DW'(pulse_flag), '0);
    @(posedge clk); #2;
    for (int a = 0; a < 5; a++) rd_check("R1 reg", a, 0);

    // R10 register map read-back
    wr(0, 32'hffff_ffff); wr(2, 5); wr(3, 9); wr(4, 6);
    rd_check("R10 ctl", 0, 3);
    rd_check("R10 width", 2, 5);
    rd_check("R10 period", 3, 9);
    rd_check("R10 delay", 4, 6);
    rd_check("R10 unmapped", 7, 0);
    wr(0, 0);

    // R3 R4 R5 immediate one-shot
    trial(0, 4, 0, 10, -1, "R3 R5 oneshot d0 w4");
    // R3 R9 delayed one-shot with retrigger during delay
    trial(3, 2, 0, 10, 0, "R3 R9 delay3 w2");
    // R4 width zero acts as one cycle
    trial(0, 0, 0, 5, -1, "R4 width0");
    // R9 retrigger during the high phase
    trial(0, 3, 0, 10, 1, "R9 retrig high");
    // R6 periodic
    trial(2, 3, 7, 30, -1, "R6 periodic p7 w3");

    // R7 disable write stops output at once
    wr(0, 0);
    @(negedge clk);
    check("R7 sync after disable", DW'(sync_out), '0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R7 stays low", DW'(sync_out), '0);
    end
    @(posedge clk); #2;

    // R8 flag sticky then cleared by writing 1
    check("R8 flag sticky", DW'(pulse_flag), DW'(1));
    wr(1, 1);
    rd_check("R8 status after clear", 1, 0);

    // R2 one enable bit alone is not enough
    for (int c = 1; c <= 2; c++) begin
      wr(0, c); wr(1, 1); wr(4, 0); wr(2, 2); wr(3, 0);
      wr(0, c);
      cmp_hit = 1'b1;
      @(posedge clk); #2;
      cmp_hit = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check("R2 sync with partial enable", DW'(sync_out), '0);
        check("R2 flag with partial enable", DW'(pulse_flag), '0);
      end
      @(posedge clk); #2;
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule